// File: doc/BRIEF.md
# Auxiliary Channel Request Framer and Reply Parser

This block runs one transaction on a display auxiliary channel. A caller presents a 4-bit command, a 20-bit target address and a byte count. The block turns these into the request byte stream and hands it byte by byte to a downstream channel encoder over a valid/ready handshake. For write-class commands, the payload comes from the caller's memory through an index output and a byte input.

Once the last request byte is accepted, the block listens for the reply. It takes in reply bytes and a completion strobe, together with a line-loss indication sampled at that strobe. It then classifies the outcome. Data from an acknowledged read is first held in an internal stage and then copied into a caller buffer of bounded size. It is copied only when it fits, so a rejected reply never touches the buffer.

The outcome is held under a done flag until the caller acknowledges it. No new request is taken before that acknowledgement.

Top module: `auxch_xact`

## Requirements
- R1: The first request byte is the command in bits 7:4 and address bits 19:16 in bits 3:0. The second byte is address bits 15:8 and the third is address bits 7:0.
- R2: For a non-zero `req_len`, a fourth byte equal to `req_len` minus one follows the address. For `req_len` of zero the request is exactly three bytes.
- R3: Commands 4'b1000, 4'b0000 and 4'b0100 are writes. For these, payload bytes 0 to `req_len`-1 are sent after the header, in index order, fetched through `pld_idx`/`pld_byte`. Every other command sends the header only.
- R4: While `tx_valid` is high and `tx_ready` is low, `tx_valid` and `tx_byte` hold their values into the next cycle.
- R5: The reply code is bits 7:4 of the first reply byte, and code 0 means acknowledge. On an acknowledge that fits, `res_ok` is set and `res_count` is the number of reply bytes minus one. Those data bytes are written in order to buffer addresses 0 upward before `done` rises.
- R6: A non-zero reply code sets `res_ok` and reports the code, with `res_count` equal to the reply bytes minus one. No buffer write is made.
- R7: A reply with no bytes sets `res_invalid`, with `res_count` zero and no buffer write.
- R8: An acknowledge whose data count exceeds `buf_size` (or MAX_LEN) sets `res_overflow`, reports `res_count` zero and writes nothing. A count equal to `buf_size` succeeds.
- R9: If `rx_hpd_lost` is high with `rx_end`, only `res_hpd` is set, whatever bytes arrived, and nothing is written.
- R10: `done` stays high until `done_ack`, and `req_ready` is low from acceptance until then. A `req_valid` during `done` is ignored. While `done` is high, exactly one of the four outcome flags is set.
- R11: After reset, `req_ready` is 1 and `tx_valid`, `done` and `buf_we` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken |
| req_cmd | input | 4 | Command code |
| req_addr | input | 20 | Target address |
| req_len | input | LEN_W | Byte count (0 to MAX_LEN) |
| pld_idx | output | LEN_W | Payload byte index being fetched |
| pld_byte | input | 8 | Payload byte at `pld_idx` |
| tx_valid | output | 1 | Request byte valid |
| tx_byte | output | 8 | Request byte |
| tx_ready | input | 1 | Encoder takes the byte |
| rx_valid | input | 1 | Reply byte strobe |
| rx_byte | input | 8 | Reply byte |
| rx_end | input | 1 | Reply complete |
| rx_hpd_lost | input | 1 | Sink disconnected, sampled with `rx_end` |
| buf_size | input | LEN_W | Caller buffer capacity in bytes |
| buf_we | output | 1 | Buffer write strobe |
| buf_addr | output | LEN_W | Buffer write address |
| buf_wdata | output | 8 | Buffer write data |
| done | output | 1 | Transaction finished, outcome valid |
| done_ack | input | 1 | Caller clears `done` |
| res_ok | output | 1 | Valid reply received |
| res_code | output | 4 | Reply code |
| res_count | output | CNT_W | Returned data byte count |
| res_invalid | output | 1 | Empty reply |
| res_overflow | output | 1 | Data did not fit the buffer |
| res_hpd | output | 1 | Disconnect seen at completion |

## Verification
The hardest state to reach is a reply that has already been fully staged but must then be discarded. This covers an acknowledge carrying one byte more than `buf_size` allows, and a full reply that ends with the disconnect input high. Both are driven with a reply one byte longer than the buffer. The bench then confirms at the buffer write port that no strobe appeared. A second hard case is a request sent while the encoder stalls on a repeating pattern. There the bench checks at every stalled cycle that the presented byte holds.

// File: rtl/auxch_pkg.sv
package auxch_pkg;

    localparam logic [3:0] CMD_NATIVE_WR  = 4'b1000;
    localparam logic [3:0] CMD_BRIDGE_WR  = 4'b0000;
    localparam logic [3:0] CMD_BRIDGE_WRC = 4'b0100;

    typedef enum logic [1:0] {PH_IDLE, PH_TX, PH_RX, PH_DONE} top_ph_e;
    typedef enum logic [1:0] {RP_IDLE, RP_CAP, RP_DRAIN, RP_FIN} rp_ph_e;

    function automatic logic cmd_is_write(input logic [3:0] c);
        return (c == CMD_NATIVE_WR) || (c == CMD_BRIDGE_WR) || (c == CMD_BRIDGE_WRC);
    endfunction

endpackage

// File: rtl/auxch_tx_seq.sv
module auxch_tx_seq
    import auxch_pkg::*;
#(
    parameter int MAX_LEN = 16,
    parameter int LEN_W   = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [3:0]       cmd_i,
    input  logic [19:0]      addr_i,
    input  logic [LEN_W-1:0] len_i,
    output logic             tx_valid,
    output logic [7:0]       tx_byte,
    input  logic             tx_ready,
    output logic [LEN_W-1:0] pld_idx,
    input  logic [7:0]       pld_byte,
    output logic             fin
);
    localparam int IDX_W = $clog2(MAX_LEN + 5);

    typedef struct packed {
        logic             busy;
        logic             fin;
        logic [3:0]       cmd;
        logic [19:0]      addr;
        logic [LEN_W-1:0] len;
        logic [IDX_W-1:0] idx;
        logic [IDX_W-1:0] last;
    } tx_st_t;

    tx_st_t q, d;
    logic [IDX_W-1:0] hdr_q;
    logic [IDX_W-1:0] hdr_new;

    assign hdr_q   = (q.len != '0) ? IDX_W'(4) : IDX_W'(3);
    assign hdr_new = (len_i != '0) ? IDX_W'(4) : IDX_W'(3);

    always_comb begin
        d     = q;
        d.fin = 1'b0;
        if (!q.busy) begin
            if (start) begin
                d.busy = 1'b1;
                d.cmd  = cmd_i;
                d.addr = addr_i;
                d.len  = len_i;
                d.idx  = '0;
                d.last = hdr_new + (cmd_is_write(cmd_i) ? IDX_W'(len_i) : IDX_W'(0))
                         - IDX_W'(1);
            end
        end else if (tx_ready) begin
            if (q.idx == q.last) begin
                d.busy = 1'b0;
                d.fin  = 1'b1;
            end else begin
                d.idx = q.idx + IDX_W'(1);
            end
        end
    end

    always_comb begin
        if (q.idx == IDX_W'(0))
            tx_byte = {q.cmd, q.addr[19:16]};
        else if (q.idx == IDX_W'(1))
            tx_byte = q.addr[15:8];
        else if (q.idx == IDX_W'(2))
            tx_byte = q.addr[7:0];
        else if ((q.idx == IDX_W'(3)) && (q.len != '0))
            tx_byte = 8'(q.len) - 8'd1;
        else
            tx_byte = pld_byte;
    end

    assign pld_idx  = LEN_W'(q.idx - hdr_q);
    assign tx_valid = q.busy;
    assign fin      = q.fin;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

endmodule

// File: rtl/auxch_rx_parse.sv
module auxch_rx_parse
    import auxch_pkg::*;
#(
    parameter int MAX_LEN = 16,
    parameter int LEN_W   = 5,
    parameter int CNT_W   = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             arm,
    input  logic             rx_valid,
    input  logic [7:0]       rx_byte,
    input  logic             rx_end,
    input  logic             rx_hpd_lost,
    input  logic [LEN_W-1:0] buf_size,
    output logic             buf_we,
    output logic [LEN_W-1:0] buf_addr,
    output logic [7:0]       buf_wdata,
    output logic             fin,
    output logic             res_ok,
    output logic [3:0]       res_code,
    output logic [CNT_W-1:0] res_count,
    output logic             res_invalid,
    output logic             res_overflow,
    output logic             res_hpd
);
    localparam int               SIX_W   = $clog2(MAX_LEN);
    localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(MAX_LEN + 2);

    typedef struct packed {
        rp_ph_e           ph;
        logic [CNT_W-1:0] cnt;
        logic [7:0]       status;
        logic [LEN_W-1:0] didx;
        logic             ok;
        logic [3:0]       code;
        logic [CNT_W-1:0] count;
        logic             inv;
        logic             ovf;
        logic             hpd;
    } rp_st_t;

    rp_st_t q, d;
    logic [7:0]       stage [MAX_LEN];
    logic [CNT_W-1:0] dcount;

    assign dcount = q.cnt - CNT_W'(1);

    always_comb begin
        d = q;
        unique case (q.ph)
            RP_IDLE: begin
                if (clear) begin
                    d.ok    = 1'b0;
                    d.code  = '0;
                    d.count = '0;
                    d.inv   = 1'b0;
                    d.ovf   = 1'b0;
                    d.hpd   = 1'b0;
                end
                if (arm) begin
                    d.ph     = RP_CAP;
                    d.cnt    = '0;
                    d.status = '0;
                end
            end
            RP_CAP: begin
                if (rx_end) begin
                    d.ph = RP_FIN;
                    if (rx_hpd_lost) begin
                        d.hpd = 1'b1;
                    end else if (q.cnt == '0) begin
                        d.inv = 1'b1;
                    end else if (q.status[7:4] != 4'h0) begin
                        d.ok    = 1'b1;
                        d.code  = q.status[7:4];
                        d.count = dcount;
                    end else if ((dcount > CNT_W'(buf_size)) || (dcount > CNT_W'(MAX_LEN))) begin
                        d.ovf = 1'b1;
                    end else begin
                        d.ok    = 1'b1;
                        d.count = dcount;
                        d.didx  = '0;
                        if (dcount != '0) d.ph = RP_DRAIN;
                    end
                end else if (rx_valid) begin
                    if (q.cnt == '0) d.status = rx_byte;
                    if (q.cnt != CNT_SAT) d.cnt = q.cnt + CNT_W'(1);
                end
            end
            RP_DRAIN: begin
                if (CNT_W'(q.didx) == (q.count - CNT_W'(1))) d.ph = RP_FIN;
                else d.didx = q.didx + LEN_W'(1);
            end
            RP_FIN:  d.ph = RP_IDLE;
            default: d.ph = RP_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if ((q.ph == RP_CAP) && rx_valid && !rx_end && (q.cnt != '0)
            && (dcount < CNT_W'(MAX_LEN)))
            stage[SIX_W'(dcount)] <= rx_byte;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign buf_we       = (q.ph == RP_DRAIN);
    assign buf_addr     = q.didx;
    assign buf_wdata    = stage[SIX_W'(q.didx)];
    assign fin          = (q.ph == RP_FIN);
    assign res_ok       = q.ok;
    assign res_code     = q.code;
    assign res_count    = q.count;
    assign res_invalid  = q.inv;
    assign res_overflow = q.ovf;
    assign res_hpd      = q.hpd;

endmodule

// File: rtl/auxch_xact.sv
module auxch_xact
    import auxch_pkg::*;
#(
    parameter  int MAX_LEN = 16,
    localparam int LEN_W   = $clog2(MAX_LEN + 1),
    localparam int CNT_W   = $clog2(MAX_LEN + 3)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [3:0]       req_cmd,
    input  logic [19:0]      req_addr,
    input  logic [LEN_W-1:0] req_len,
    output logic [LEN_W-1:0] pld_idx,
    input  logic [7:0]       pld_byte,
    output logic             tx_valid,
    output logic [7:0]       tx_byte,
    input  logic             tx_ready,
    input  logic             rx_valid,
    input  logic [7:0]       rx_byte,
    input  logic             rx_end,
    input  logic             rx_hpd_lost,
    input  logic [LEN_W-1:0] buf_size,
    output logic             buf_we,
    output logic [LEN_W-1:0] buf_addr,
    output logic [7:0]       buf_wdata,
    output logic             done,
    input  logic             done_ack,
    output logic             res_ok,
    output logic [3:0]       res_code,
    output logic [CNT_W-1:0] res_count,
    output logic             res_invalid,
    output logic             res_overflow,
    output logic             res_hpd
);
    typedef struct packed {
        top_ph_e ph;
    } top_st_t;

    top_st_t q, d;
    logic accept;
    logic tx_fin;
    logic rx_fin;

    assign accept = req_valid && (q.ph == PH_IDLE);

    always_comb begin
        d = q;
        unique case (q.ph)
            PH_IDLE: if (req_valid) d.ph = PH_TX;
            PH_TX:   if (tx_fin)    d.ph = PH_RX;
            PH_RX:   if (rx_fin)    d.ph = PH_DONE;
            PH_DONE: if (done_ack)  d.ph = PH_IDLE;
            default: d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign req_ready = (q.ph == PH_IDLE);
    assign done      = (q.ph == PH_DONE);

    auxch_tx_seq #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (accept),
        .cmd_i    (req_cmd),
        .addr_i   (req_addr),
        .len_i    (req_len),
        .tx_valid (tx_valid),
        .tx_byte  (tx_byte),
        .tx_ready (tx_ready),
        .pld_idx  (pld_idx),
        .pld_byte (pld_byte),
        .fin      (tx_fin)
    );

    auxch_rx_parse #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_rx (
        .clk          (clk),
        .rst_n        (rst_n),
        .clear        (accept),
        .arm          (tx_fin),
        .rx_valid     (rx_valid),
        .rx_byte      (rx_byte),
        .rx_end       (rx_end),
        .rx_hpd_lost  (rx_hpd_lost),
        .buf_size     (buf_size),
        .buf_we       (buf_we),
        .buf_addr     (buf_addr),
        .buf_wdata    (buf_wdata),
        .fin          (rx_fin),
        .res_ok       (res_ok),
        .res_code     (res_code),
        .res_count    (res_count),
        .res_invalid  (res_invalid),
        .res_overflow (res_overflow),
        .res_hpd      (res_hpd)
    );

endmodule

// File: rtl/auxch_xact_chk.sv
module auxch_xact_chk #(
    parameter int LEN_W = 5,
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_ready,
    input logic             tx_valid,
    input logic             tx_ready,
    input logic [7:0]       tx_byte,
    input logic             buf_we,
    input logic [LEN_W-1:0] buf_addr,
    input logic [LEN_W-1:0] buf_size,
    input logic             done,
    input logic             done_ack,
    input logic             res_ok,
    input logic [CNT_W-1:0] res_count,
    input logic             res_invalid,
    input logic             res_overflow,
    input logic             res_hpd
);
    AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_byte))); // R4

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($countones({res_ok, res_invalid, res_overflow, res_hpd}) == 1)); // R10

    AST_DONE_BLOCKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (done || tx_valid) |-> !req_ready); // R10

    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !done_ack) |=> done); // R10

    AST_BUF_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we |-> (buf_addr < buf_size)); // R8

    AST_INVALID_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (done && res_invalid) |-> (res_count == '0)); // R7

    AST_NO_WRITE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !buf_we); // R5

endmodule

bind auxch_xact auxch_xact_chk #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_ready    (req_ready),
    .tx_valid     (tx_valid),
    .tx_ready     (tx_ready),
    .tx_byte      (tx_byte),
    .buf_we       (buf_we),
    .buf_addr     (buf_addr),
    .buf_size     (buf_size),
    .done         (done),
    .done_ack     (done_ack),
    .res_ok       (res_ok),
    .res_count    (res_count),
    .res_invalid  (res_invalid),
    .res_overflow (res_overflow),
    .res_hpd      (res_hpd)
);

// File: tb/auxch_xact_bench.sv
module auxch_xact_bench;
    localparam int CLK_PERIOD = 10;
    localparam int MAX_LEN    = 16;
    localparam int LEN_W      = $clog2(MAX_LEN + 1);
    localparam int CNT_W      = $clog2(MAX_LEN + 3);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_ready;
    logic [3:0] req_cmd = '0;
    logic [19:0] req_addr = '0;
    logic [LEN_W-1:0] req_len = '0;
    logic [LEN_W-1:0] pld_idx;
    logic [7:0] pld_byte;
    logic tx_valid, tx_ready;
    logic [7:0] tx_byte;
    logic rx_valid = 1'b0, rx_end = 1'b0, rx_hpd_lost = 1'b0;
    logic [7:0] rx_byte = '0;
    logic [LEN_W-1:0] buf_size = LEN_W'(MAX_LEN);
    logic buf_we;
    logic [LEN_W-1:0] buf_addr;
    logic [7:0] buf_wdata;
    logic done, done_ack = 1'b0;
    logic res_ok, res_invalid, res_overflow, res_hpd;
    logic [3:0] res_code;
    logic [CNT_W-1:0] res_count;

    int checks = 0, fails = 0, cyc = 0, txn = 0, bwrites = 0;
    bit stall_mode = 1'b0;
    logic [7:0] pmem [0:31];
    logic [7:0] bmem [0:31];
    logic [7:0] txq  [0:39];
    logic [7:0] rq   [0:23];
    logic       prev_stall = 1'b0;
    logic [7:0] prev_byte = '0;

    always #(CLK_PERIOD/2) clk = ~clk;
    assign pld_byte = pmem[pld_idx];

    auxch_xact #(.MAX_LEN(MAX_LEN)) u_auxch_xact (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        tx_ready <= !stall_mode || ((cyc % 3) == 2);
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails);
            $finish;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_stall) chk("R4 hold", {tx_valid, tx_byte}, {1'b1, prev_byte});
            prev_stall = tx_valid && !tx_ready;
            prev_byte  = tx_byte;
            if (tx_valid && tx_ready) begin txq[txn] = tx_byte; txn++; end
            if (buf_we) begin bmem[buf_addr] = buf_wdata; bwrites++; end
        end
    end

    task automatic send_req(input logic [3:0] cmd, input logic [19:0] addr, input int len, input bit stall);
        logic [7:0] exp [0:39];
        int n;
        bit wr;
        wr = (cmd == 4'b1000) || (cmd == 4'b0000) || (cmd == 4'b0100);
        exp[0] = {cmd, addr[19:16]}; exp[1] = addr[15:8]; exp[2] = addr[7:0];
        n = 3;
        if (len > 0) begin exp[3] = 8'(len - 1); n = 4; end
        if (wr) for (int i = 0; i < len; i++) begin exp[n] = pmem[i]; n++; end
        stall_mode = stall; txn = 0; bwrites = 0;
        @(negedge clk);
        req_valid = 1'b1; req_cmd = cmd; req_addr = addr; req_len = LEN_W'(len);
        @(negedge clk);
        req_valid = 1'b0;
        while (txn < n) @(negedge clk);
        repeat (4) @(negedge clk);
        stall_mode = 1'b0;
        chk("R2 request length", txn, n);
        for (int i = 0; i < n; i++)
            chk(i < 3 ? "R1 header byte" : (wr ? "R3 payload byte" : "R2 length byte"), txq[i], exp[i]);
    endtask

    task automatic send_reply(input int n, input bit hpd);
        for (int i = 0; i < n; i++) begin
            rx_valid = 1'b1; rx_byte = rq[i];
            @(negedge clk);
        end
        rx_valid = 1'b0; rx_end = 1'b1; rx_hpd_lost = hpd;
        @(negedge clk);
        rx_end = 1'b0; rx_hpd_lost = 1'b0;
        while (!done) @(negedge clk);
    endtask

    task automatic ack();
        done_ack = 1'b1;
        @(negedge clk);
        done_ack = 1'b0;
        chk("R10 ready after ack", {req_ready, done}, 2'b10);
    endtask

    task automatic outcome(input string req, input logic [3:0] flags, input int code, input int cnt, input int writes);
        chk(req, {res_ok, res_invalid, res_overflow, res_hpd}, flags);
        chk(req, res_code, code);
        chk(req, res_count, cnt);
        chk(req, bwrites, writes);
    endtask

    task automatic t_reset();
        chk("R11 reset", {req_ready, tx_valid, done, buf_we}, 4'b1000);
    endtask

    task automatic t_native_write();
        send_req(4'b1000, 20'hA5C3E, 3, 1'b1);
        rq[0] = 8'h00;
        send_reply(1, 1'b0);
        outcome("R5 write ack", 4'b1000, 0, 0, 0);
        ack();
    endtask

    task automatic t_native_read();
        send_req(4'b1001, 20'h00102, 4, 1'b0);
        rq[0] = 8'h00; rq[1] = 8'h11; rq[2] = 8'h22; rq[3] = 8'h33; rq[4] = 8'h44;
        buf_size = 5'd4;
        send_reply(5, 1'b0);
        outcome("R5 read ack", 4'b1000, 0, 4, 4);
        for (int i = 0; i < 4; i++) chk("R5 buffer data", bmem[i], rq[i+1]);
        ack();
        buf_size = LEN_W'(MAX_LEN);
    endtask

    task automatic t_zero_len();
        send_req(4'b0001, 20'h00050, 0, 1'b0);
        rq[0] = 8'h00;
        send_reply(1, 1'b0);
        outcome("R2 zero length reply", 4'b1000, 0, 0, 0);
        ack();
    endtask

    task automatic t_bridge_cmds();
        send_req(4'b0100, 20'hF0F0F, 2, 1'b1);
        rq[0] = 8'h00;
        send_reply(1, 1'b0);
        ack();
        send_req(4'b0000, 20'h12345, 1, 1'b0);
        send_reply(1, 1'b0);
        ack();
        send_req(4'b0010, 20'h00ABC, 5, 1'b0);
        send_reply(1, 1'b0);
        ack();
    endtask

    task automatic t_non_ack();
        send_req(4'b1001, 20'h00200, 2, 1'b0);
        rq[0] = 8'h20;
        send_reply(1, 1'b0);
        outcome("R6 defer", 4'b1000, 2, 0, 0);
        ack();
        send_req(4'b1001, 20'h00200, 2, 1'b0);
        rq[0] = 8'h10; rq[1] = 8'h07;
        send_reply(2, 1'b0);
        outcome("R6 nack with byte", 4'b1000, 1, 1, 0);
        ack();
    endtask

    task automatic t_invalid();
        send_req(4'b1001, 20'h00300, 1, 1'b0);
        send_reply(0, 1'b0);
        outcome("R7 empty reply", 4'b0100, 0, 0, 0);
        ack();
    endtask

    task automatic t_overflow();
        buf_size = 5'd2;
        send_req(4'b1001, 20'h00400, 3, 1'b0);
        rq[0] = 8'h00; rq[1] = 8'hA1; rq[2] = 8'hA2; rq[3] = 8'hA3;
        send_reply(4, 1'b0);
        outcome("R8 overflow", 4'b0010, 0, 0, 0);
        ack();
        send_req(4'b1001, 20'h00400, 2, 1'b0);
        rq[0] = 8'h00; rq[1] = 8'hB1; rq[2] = 8'hB2;
        send_reply(3, 1'b0);
        outcome("R8 exact fit", 4'b1000, 0, 2, 2);
        chk("R8 fit data", {bmem[0], bmem[1]}, 16'hB1B2);
        ack();
        buf_size = LEN_W'(MAX_LEN);
    endtask

    task automatic t_hpd();
        send_req(4'b1001, 20'h00500, 1, 1'b0);
        send_reply(0, 1'b1);
        outcome("R9 disconnect empty", 4'b0001, 0, 0, 0);
        ack();
        buf_size = 5'd2;
        send_req(4'b1001, 20'h00500, 3, 1'b0);
        rq[0] = 8'h00; rq[1] = 8'hC1; rq[2] = 8'hC2; rq[3] = 8'hC3;
        send_reply(4, 1'b1);
        outcome("R9 disconnect full", 4'b0001, 0, 0, 0);
        ack();
        buf_size = LEN_W'(MAX_LEN);
    endtask

    task automatic t_done_hold();
        send_req(4'b1001, 20'h00600, 1, 1'b0);
        rq[0] = 8'h00; rq[1] = 8'h5A;
        send_reply(2, 1'b0);
        txn = 0;
        req_valid = 1'b1; req_cmd = 4'b1000; req_len = 5'd1;
        repeat (4) @(negedge clk);
        req_valid = 1'b0;
        chk("R10 done held", {done, req_ready, tx_valid}, 3'b100);
        chk("R10 request ignored", txn, 0);
        outcome("R10 result kept", 4'b1000, 0, 1, 1);
        ack();
        repeat (3) @(negedge clk);
        chk("R10 no late request", {txn, tx_valid}, 33'd0);
    endtask

    initial begin
        for (int i = 0; i < 32; i++) pmem[i] = 8'(8'h40 + i * 7);
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_native_write();
        t_native_read();
        t_zero_len();
        t_bridge_cmds();
        t_non_ack();
        t_invalid();
        t_overflow();
        t_hpd();
        t_done_hold();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule